// File: doc/BRIEF.md
# Deferred-Commit Write Staging Buffer

This block sits between a column command stream and a storage array. Each column write command carries a column address and a tag. The write data for that command arrives a fixed number of cycles later, and the block matches it to the command and parks it in a small in-order staging queue. Nothing reaches the array at that point. A later, separate retire event moves the oldest staged entry out onto the array write port.

A byte mask may come with the retire, on the same cycle. When it does, it selects which bytes of the staged word the array takes. When no mask comes with the retire, the whole word is written. The bytes that are not enabled keep whatever the array held before, because the write port carries a per-byte enable. The block raises a protocol flag when a data strobe does not line up with a command issued exactly the write latency earlier. It raises a second flag when a retire finds nothing staged.

Top module: `staged_write_commit`

## Requirements
- R1: While `rst` is high on a clock edge, the next cycle shows `arr_we`, `err_proto` and `err_no_pending` low, and the staging queue is emptied.
- R2: Data presented with `din_valid` exactly `WR_LAT` clock edges after a sampled `cmd_valid` is staged together with that command's `cmd_col` and `cmd_tag`.
- R3: A retire (`ret_valid`) with at least one staged entry makes `arr_we` high in the following cycle. In that cycle `arr_addr`, `arr_wdata` and `arr_tag` equal the column, data and tag of the oldest staged entry, and the entry is removed.
- R4: When `ret_mask_valid` is high with a retire, `arr_be` in the commit cycle equals `ret_mask`. Bit i enables byte i, which is `arr_wdata[8*i+7:8*i]`. A zero bit leaves that array byte unchanged.
- R5: When `ret_mask_valid` is low with a retire, `arr_be` in the commit cycle is all ones.
- R6: Up to `DEPTH` (default 2) entries can be staged at once. Retires commit them in the order their data arrived, so a second write's data may arrive before the first retire.
- R7: A retire while nothing is staged sets `err_no_pending` high for one cycle and leaves `arr_we` low.
- R8: A `din_valid` on an edge with no command issued `WR_LAT` edges earlier sets `err_proto` high the next cycle, and the data is not staged.
- R9: A command whose data strobe is absent `WR_LAT` edges later sets `err_proto` high the next cycle, and no entry is staged for it.
- R10: Data that arrives on time while the queue is full and no retire is taken on that edge is dropped, and `err_proto` is set the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Column write command strobe |
| cmd_col | input | COL_W | Column address of the write |
| cmd_tag | input | TAG_W | Tag carried through to the commit |
| din_valid | input | 1 | Write data strobe |
| din_data | input | 8*NBYTES | Write data word |
| ret_valid | input | 1 | Retire strobe: commit the oldest staged entry |
| ret_mask_valid | input | 1 | A byte mask accompanies this retire |
| ret_mask | input | NBYTES | Byte mask, bit i enables byte i |
| arr_we | output | 1 | Array write enable (registered) |
| arr_addr | output | COL_W | Array write address |
| arr_wdata | output | 8*NBYTES | Array write data |
| arr_be | output | NBYTES | Array byte enables |
| arr_tag | output | TAG_W | Tag of the committed entry |
| err_proto | output | 1 | Data timing or staging overflow error pulse |
| err_no_pending | output | 1 | Retire with empty queue pulse |

## Verification
The assertions assume that a retire never arrives on the same edge as the data it is meant to commit, so every retire refers only to entries staged on earlier edges. They also assume that reset is held for at least one edge before any command, mask or strobe matters. The stimulus keeps to this. Every retire in the vector table and in the directed tests comes at least one edge after its data strobe, and the only strobes that break the timing rules are the deliberate protocol-error tests. Those tests check the flags and then confirm through a later retire that nothing was staged.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  localparam int WBR_COL_W  = 6;
  localparam int WBR_TAG_W  = 4;
  localparam int WBR_NBYTES = 4;
  localparam int WBR_WR_LAT = 4;
  localparam int WBR_DEPTH  = 2;
endpackage

// File: rtl/wbr_lat_pipe.sv
module wbr_lat_pipe #(
  parameter int LAT = 4,
  parameter int W   = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_payload,
  output logic         out_valid,
  output logic [W-1:0] out_payload
);
  logic [LAT-1:0] vld;
  logic [W-1:0]   pay [LAT];

  always_ff @(posedge clk) begin
    if (rst) vld[0] <= 1'b0;
    else     vld[0] <= in_valid;
    pay[0] <= in_payload;
  end

  genvar g;
  generate
    for (g = 1; g < LAT; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) vld[g] <= 1'b0;
        else     vld[g] <= vld[g-1];
        pay[g] <= pay[g-1];
      end
    end
  endgenerate

  assign out_valid   = vld[LAT-1];
  assign out_payload = pay[LAT-1];
endmodule

// File: rtl/wbr_fifo.sv
module wbr_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 42
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10 / R6: occupancy never exceeds the configured depth
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R6: an accepted push into a full queue is only possible alongside a pop
  p_full_push_needs_pop_r6: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> full);
endmodule

// File: rtl/staged_write_commit.sv
module staged_write_commit
  import wbr_pkg::*;
#(
  parameter int COL_W  = WBR_COL_W,
  parameter int TAG_W  = WBR_TAG_W,
  parameter int NBYTES = WBR_NBYTES,
  parameter int WR_LAT = WBR_WR_LAT,
  parameter int DEPTH  = WBR_DEPTH
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic [COL_W-1:0]      cmd_col,
  input  logic [TAG_W-1:0]      cmd_tag,
  input  logic                  din_valid,
  input  logic [8*NBYTES-1:0]   din_data,
  input  logic                  ret_valid,
  input  logic                  ret_mask_valid,
  input  logic [NBYTES-1:0]     ret_mask,
  output logic                  arr_we,
  output logic [COL_W-1:0]      arr_addr,
  output logic [8*NBYTES-1:0]   arr_wdata,
  output logic [NBYTES-1:0]     arr_be,
  output logic [TAG_W-1:0]      arr_tag,
  output logic                  err_proto,
  output logic                  err_no_pending
);
  localparam int DW = 8 * NBYTES;
  localparam int CT = COL_W + TAG_W;
  localparam int EW = CT + DW;

  logic          exp_valid;
  logic [CT-1:0] exp_ct;
  logic          hit, pop, drop;
  logic          q_empty, q_full;
  logic [EW-1:0] q_head;
  logic [COL_W-1:0]  head_col;
  logic [TAG_W-1:0]  head_tag;
  logic [DW-1:0]     head_data;

  wbr_lat_pipe #(.LAT(WR_LAT), .W(CT)) u_lat (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (cmd_valid),
    .in_payload ({cmd_col, cmd_tag}),
    .out_valid  (exp_valid),
    .out_payload(exp_ct)
  );

  assign hit  = din_valid && exp_valid;
  assign pop  = ret_valid && !q_empty;
  assign drop = hit && q_full && !pop;

  wbr_fifo #(.DEPTH(DEPTH), .W(EW)) u_q (
    .clk  (clk),
    .rst  (rst),
    .push (hit),
    .pop  (ret_valid),
    .wdata({exp_ct, din_data}),
    .rdata(q_head),
    .empty(q_empty),
    .full (q_full)
  );

  assign {head_col, head_tag, head_data} = q_head;

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we         <= 1'b0;
      arr_addr       <= '0;
      arr_wdata      <= '0;
      arr_be         <= '0;
      arr_tag        <= '0;
      err_proto      <= 1'b0;
      err_no_pending <= 1'b0;
    end else begin
      arr_we         <= pop;
      err_proto      <= (din_valid != exp_valid) || drop;
      err_no_pending <= ret_valid && q_empty;
      if (pop) begin
        arr_addr  <= head_col;
        arr_wdata <= head_data;
        arr_tag   <= head_tag;
        arr_be    <= ret_mask_valid ? ret_mask : '1;
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!arr_we && !err_proto && !err_no_pending));
  p_we_from_retire_r3: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> $past(ret_valid));
  p_mask_applied_r4: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !q_empty && ret_mask_valid) |=> (arr_be == $past(ret_mask)));
  p_all_bytes_r5: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !q_empty && !ret_mask_valid) |=> (&arr_be));
  p_empty_retire_r7: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && q_empty) |=> (!arr_we && err_no_pending));
  p_stray_data_r8: assert property (@(posedge clk) disable iff (rst)
    (din_valid && !exp_valid) |=> err_proto);
  p_missing_data_r9: assert property (@(posedge clk) disable iff (rst)
    (exp_valid && !din_valid) |=> err_proto);
  p_drop_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (din_valid && exp_valid && q_full && !ret_valid) |=> err_proto);
endmodule

// File: tb/staged_write_commit_bench.sv
module staged_write_commit_bench;
  localparam int COL_W = 6, TAG_W = 4, NB = 4, LAT = 4, DEPTH = 2;

  logic clk = 1'b0;
  logic rst;
  logic cmd_valid, din_valid, ret_valid, ret_mask_valid;
  logic [COL_W-1:0] cmd_col;
  logic [TAG_W-1:0] cmd_tag;
  logic [31:0]      din_data;
  logic [NB-1:0]    ret_mask;
  logic             arr_we, err_proto, err_no_pending;
  logic [COL_W-1:0] arr_addr;
  logic [31:0]      arr_wdata;
  logic [NB-1:0]    arr_be;
  logic [TAG_W-1:0] arr_tag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  staged_write_commit #(.COL_W(COL_W), .TAG_W(TAG_W), .NBYTES(NB),
                        .WR_LAT(LAT), .DEPTH(DEPTH)) u_staged_write_commit (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
    .cmd_tag(cmd_tag), .din_valid(din_valid), .din_data(din_data),
    .ret_valid(ret_valid), .ret_mask_valid(ret_mask_valid),
    .ret_mask(ret_mask), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_be(arr_be), .arr_tag(arr_tag),
    .err_proto(err_proto), .err_no_pending(err_no_pending));

  // {col[46:41], tag[40:37], data[36:5], mask_valid[4], mask[3:0]}
  localparam logic [46:0] VEC [6] = '{
    {6'd3,  4'h1, 32'hA1B2C3D4, 1'b0, 4'h0},
    {6'd17, 4'h2, 32'h11223344, 1'b1, 4'b0101},
    {6'd63, 4'hF, 32'hDEADBEEF, 1'b1, 4'b0000},
    {6'd0,  4'h7, 32'h00FF00FF, 1'b1, 4'b1000},
    {6'd42, 4'h9, 32'hCAFEF00D, 1'b0, 4'b0011},
    {6'd21, 4'h4, 32'h5A5AA5A5, 1'b1, 4'b1111}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    cmd_valid = 0; din_valid = 0; ret_valid = 0; ret_mask_valid = 0;
    cmd_col = '0; cmd_tag = '0; din_data = '0; ret_mask = '0;
  endtask

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [COL_W-1:0] c, input logic [TAG_W-1:0] t);
    cmd_valid = 1; cmd_col = c; cmd_tag = t;
  endtask

  task automatic retire(input logic mv, input logic [NB-1:0] m);
    ret_valid = 1; ret_mask_valid = mv; ret_mask = m;
  endtask

  function automatic logic [63:0] commit_word(input logic [COL_W-1:0] c,
      input logic [TAG_W-1:0] t, input logic [31:0] d, input logic mv,
      input logic [NB-1:0] m);
    return {17'd0, 1'b1, c, t, d, (mv ? m : 4'hF)};
  endfunction

  function automatic logic [63:0] observed();
    return {17'd0, arr_we, arr_addr, arr_tag, arr_wdata, arr_be};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    step(); step();
    // R1: outputs quiet after reset
    check("R1 reset outputs", {61'd0, arr_we, err_proto, err_no_pending}, 64'd0);
    rst = 0;
    step();
    // R1: queue empty after reset, so a retire finds nothing (R7)
    retire(1'b0, '0); step(); idle();
    check("R1/R7 retire after reset", {62'd0, arr_we, err_no_pending}, 64'd1);

    // Table walk: R2, R3, R4, R5
    for (int i = 0; i < 6; i++) begin
      send_cmd(VEC[i][46:41], VEC[i][40:37]); step(); idle();
      for (int k = 0; k < LAT-1; k++) step();
      din_valid = 1; din_data = VEC[i][36:5]; step(); idle();
      check("R2 on-time data no error", {63'd0, err_proto}, 64'd0);
      retire(VEC[i][4], VEC[i][3:0]); step(); idle();
      check(VEC[i][4] ? "R3/R4 masked commit" : "R3/R5 full commit",
            observed(), commit_word(VEC[i][46:41], VEC[i][40:37],
                                    VEC[i][36:5], VEC[i][4], VEC[i][3:0]));
      step();
      check("R3 single-cycle write", {63'd0, arr_we}, 64'd0);
    end

    // R6: two staged entries, committed oldest first
    send_cmd(6'd5, 4'hA); step();
    send_cmd(6'd6, 4'hB); step(); idle();
    step(); step();
    din_valid = 1; din_data = 32'h01020304; step();
    din_valid = 1; din_data = 32'h05060708; step(); idle();
    check("R6 second data accepted", {63'd0, err_proto}, 64'd0);
    retire(1'b1, 4'b0110); step(); idle();
    check("R6/R4 first retire oldest", observed(),
          commit_word(6'd5, 4'hA, 32'h01020304, 1'b1, 4'b0110));
    retire(1'b0, 4'b0001); step(); idle();
    check("R6/R5 second retire", observed(),
          commit_word(6'd6, 4'hB, 32'h05060708, 1'b0, 4'b0001));

    // R8: stray data strobe is flagged and not staged
    din_valid = 1; din_data = 32'hBAD0BAD0; step(); idle();
    check("R8 stray data flag", {63'd0, err_proto}, 64'd1);
    retire(1'b0, '0); step(); idle();
    check("R8 stray data not staged", {62'd0, arr_we, err_no_pending}, 64'd1);

    // R9: missing data is flagged and nothing staged
    send_cmd(6'd9, 4'h3); step(); idle();
    for (int k = 0; k < LAT-1; k++) step();
    check("R9 no flag before due edge", {63'd0, err_proto}, 64'd0);
    step();
    check("R9 missing data flag", {63'd0, err_proto}, 64'd1);
    retire(1'b1, 4'hF); step(); idle();
    check("R9 nothing staged", {62'd0, arr_we, err_no_pending}, 64'd1);

    // R10: third entry while full is dropped
    send_cmd(6'd10, 4'h1); step();
    send_cmd(6'd11, 4'h2); step();
    send_cmd(6'd12, 4'h3); step(); idle();
    step();
    din_valid = 1; din_data = 32'hAAAA0001; step();
    din_valid = 1; din_data = 32'hAAAA0002; step();
    check("R10 fill without error", {63'd0, err_proto}, 64'd0);
    din_valid = 1; din_data = 32'hAAAA0003; step(); idle();
    check("R10 overflow flag", {63'd0, err_proto}, 64'd1);
    retire(1'b0, '0); step(); idle();
    check("R10 first kept", observed(),
          commit_word(6'd10, 4'h1, 32'hAAAA0001, 1'b0, '0));
    retire(1'b0, '0); step(); idle();
    check("R10 second kept", observed(),
          commit_word(6'd11, 4'h2, 32'hAAAA0002, 1'b0, '0));
    retire(1'b0, '0); step(); idle();
    check("R10/R7 third dropped", {62'd0, arr_we, err_no_pending}, 64'd1);

    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule